// File: doc/BRIEF.md
# Interval Timer with Watchdog

A free-running prescaler divides the system clock and, through a selectable tap, steps an 8-bit interval counter. Each time that counter wraps it raises a one-cycle interval interrupt. The same wrap also advances a 6-bit watchdog counter.

The watchdog counter is compared against a programmable limit held in a watchdog configuration register. When the two match, the watchdog counter returns to zero and the block raises one of two one-cycle pulses. A mode bit chooses between a watchdog interrupt and a reset request to the surrounding device. Firmware keeps the watchdog quiet by writing the configuration register. Any write to that register clears the watchdog counter.

Software reaches the block through a single-cycle register write strobe and a combinational read port. The port holds four 8-bit locations: control, interval count, watchdog configuration and watchdog count.

Top module: `tick_watchdog`

## Requirements
- R1: After reset the control location reads 0x07, the watchdog configuration reads 0x3F, both counts read 0, and bit_irq, wdt_irq and rst_req are low.
- R2: With tap select s (control bits 2:0), the interval count (address 1) increments once every 2^(s+3) clock cycles. The count is measured from the clear edge, so m cycles after a clear it reads floor(m / 2^(s+3)) mod 256.
- R3: The interval count is read at address 1, and a write to address 1 has no effect on it.
- R4: bit_irq is a one-cycle pulse in the cycle the interval count wraps from 255 to 0. After a clear, the first pulse comes 256·2^(s+3) cycles later.
- R5: Writing the control location (address 0) with bit 3 set zeroes the prescaler and the interval count, and loads the tap select from bits 2:0. Bit 3 always reads back as 0.
- R6: The watchdog count (address 3) advances by one on each interval wrap and holds otherwise.
- R7: With mode bit 0 (bit 6 of address 2), a wrap that brings the watchdog count equal to the limit (bits 5:0) gives a one-cycle wdt_irq and returns the count to 0. A limit of 0 means 64 wraps.
- R8: With mode bit 1, the same match gives a one-cycle rst_req instead, and wdt_irq stays low.
- R9: Any write to address 2 zeroes the watchdog count. This holds even when the write lands in the same cycle as an interval wrap, and the write then postpones the next match.
- R10: Address 2 reads back bit 7 as 0, bit 6 as the mode bit and bits 5:0 as the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 interval count, 2 watchdog configuration, 3 watchdog count) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr, combinational |
| bit_irq | output | 1 | Interval wrap interrupt pulse |
| wdt_irq | output | 1 | Watchdog match interrupt pulse (mode 0) |
| rst_req | output | 1 | Watchdog match reset request pulse (mode 1) |

## Verification
The hardest case to reach is a watchdog kick that lands in exactly the clock cycle in which the interval counter wraps. The write must win, and the wrap must not advance the watchdog count.

The bench gets there by clearing the prescaler and interval counter with a control write, which makes every later wrap fall on a known cycle. It then counts clocks from that clear and issues the configuration write so that it lands on the wrap edge.

Random tap, limit and mode choices then check the firing distance against the computed period, confirming that only the selected pulse appears.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int PRESC_BITS   = 10;
    localparam int ICNT_BITS    = 8;
    localparam int WCNT_BITS    = 6;
    localparam int TSEL_BITS    = 3;
    localparam int TAP_LOW      = 2;
    localparam int REG_BITS     = 8;

    typedef enum logic [1:0] {
        LOC_CTRL = 2'd0,
        LOC_ICNT = 2'd1,
        LOC_WCFG = 2'd2,
        LOC_WCNT = 2'd3
    } loc_e;

    typedef struct packed {
        logic irq;
        logic rst;
    } wd_evt_t;

    function automatic logic [REG_BITS-1:0] zext_cnt(input logic [REG_BITS-1:0] v);
        return v;
    endfunction

endpackage

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
    parameter int PRESC_W  = tw_pkg::PRESC_BITS,
    parameter int SEL_W    = tw_pkg::TSEL_BITS,
    parameter int TAP_BASE = tw_pkg::TAP_LOW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int NTAP = 1 << SEL_W;

    logic [PRESC_W-1:0] div_q;
    logic [NTAP-1:0]    tap_hit;

    always_ff @(posedge clk) begin
        if (rst || clr_i) div_q <= '0;
        else              div_q <= div_q + 1'b1;
    end

    // carry out of tap bit: all bits up to and including the tap are ones
    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        assign tap_hit[g] = &div_q[TAP_BASE+g:0];
    end

    assign tick_o = tap_hit[sel_i];

    AST_TICK_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick_o && !clr_i) |=> (div_q[TAP_BASE:0] == '0)); // R2

endmodule

// File: rtl/tw_interval.sv
module tw_interval #(
    parameter int CNT_W = tw_pkg::ICNT_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;

    assign ovf_o = tick_i && !clr_i && (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= ovf_o;
            if (tick_i) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
    assign irq_o = irq_q;

    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (cnt_q == '0)); // R4
    AST_ICNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !clr_i) |=> $stable(cnt_q)); // R2
    AST_ICNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0 && !irq_o)); // R5

endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog #(
    parameter int CNT_W = tw_pkg::WCNT_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ovf_i,
    input  logic             kick_i,
    input  logic             mode_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] cnt_o,
    output tw_pkg::wd_evt_t  evt_o
);
    import tw_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             hit;
    wd_evt_t          evt_q;

    // limit 0 is reached on wrap-around, giving the full 2^CNT_W period
    assign cnt_nxt = cnt_q + 1'b1;
    assign hit     = ovf_i && (cnt_nxt == limit_i);

    always_ff @(posedge clk) begin
        if (rst || kick_i) begin
            cnt_q <= '0;
            evt_q <= '0;
        end else begin
            evt_q.irq <= hit && !mode_i;
            evt_q.rst <= hit && mode_i;
            if (ovf_i) cnt_q <= hit ? '0 : cnt_nxt;
        end
    end

    assign cnt_o = cnt_q;
    assign evt_o = evt_q;

    AST_WD_KICK: assert property (@(posedge clk) disable iff (rst)
        kick_i |=> (cnt_q == '0 && !evt_q.irq && !evt_q.rst)); // R9
    AST_WD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ovf_i && !kick_i) |=> $stable(cnt_q)); // R6
    AST_WD_ONE_EVT: assert property (@(posedge clk) disable iff (rst)
        !(evt_q.irq && evt_q.rst)); // R8
    AST_WD_RST_MODE: assert property (@(posedge clk) disable iff (rst)
        evt_q.rst |-> $past(mode_i)); // R8
    AST_WD_IRQ_MODE: assert property (@(posedge clk) disable iff (rst)
        evt_q.irq |-> !$past(mode_i)); // R7
    AST_WD_FIRE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (evt_q.irq || evt_q.rst) |-> (cnt_q == '0)); // R7

endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
    parameter int PRESC_W  = tw_pkg::PRESC_BITS,
    parameter int ICNT_W   = tw_pkg::ICNT_BITS,
    parameter int WCNT_W   = tw_pkg::WCNT_BITS,
    parameter int SEL_W    = tw_pkg::TSEL_BITS,
    parameter int TAP_BASE = tw_pkg::TAP_LOW,
    parameter int DATA_W   = tw_pkg::REG_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              bit_irq,
    output logic              wdt_irq,
    output logic              rst_req
);
    import tw_pkg::*;

    localparam int                 CLR_POS   = SEL_W;
    localparam int                 MODE_POS  = WCNT_W;
    localparam logic [SEL_W-1:0]   SEL_RESET = '1;
    localparam logic [WCNT_W-1:0]  LIM_RESET = '1;

    logic [SEL_W-1:0]  sel_q;
    logic              mode_q;
    logic [WCNT_W-1:0] limit_q;
    logic              clr_stb;
    logic              kick_stb;
    logic              tick;
    logic              ovf;
    logic [ICNT_W-1:0] icnt;
    logic [WCNT_W-1:0] wcnt;
    wd_evt_t           evt;
    loc_e              loc;

    assign loc      = loc_e'(addr);
    assign clr_stb  = wr_en && (loc == LOC_CTRL) && wr_data[CLR_POS];
    assign kick_stb = wr_en && (loc == LOC_WCFG);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= SEL_RESET;
            mode_q  <= 1'b0;
            limit_q <= LIM_RESET;
        end else if (wr_en) begin
            if (loc == LOC_CTRL) sel_q <= wr_data[SEL_W-1:0];
            if (loc == LOC_WCFG) begin
                mode_q  <= wr_data[MODE_POS];
                limit_q <= wr_data[WCNT_W-1:0];
            end
        end
    end

    tw_prescaler #(.PRESC_W(PRESC_W), .SEL_W(SEL_W), .TAP_BASE(TAP_BASE)) u_presc (
        .clk(clk), .rst(rst), .clr_i(clr_stb), .sel_i(sel_q), .tick_o(tick)
    );

    tw_interval #(.CNT_W(ICNT_W)) u_ivl (
        .clk(clk), .rst(rst), .clr_i(clr_stb), .tick_i(tick),
        .cnt_o(icnt), .ovf_o(ovf), .irq_o(bit_irq)
    );

    tw_watchdog #(.CNT_W(WCNT_W)) u_wd (
        .clk(clk), .rst(rst), .ovf_i(ovf), .kick_i(kick_stb),
        .mode_i(mode_q), .limit_i(limit_q), .cnt_o(wcnt), .evt_o(evt)
    );

    assign wdt_irq = evt.irq;
    assign rst_req = evt.rst;

    always_comb begin
        rd_data = '0;
        unique case (loc)
            LOC_CTRL: rd_data[SEL_W-1:0] = sel_q;
            LOC_ICNT: rd_data[ICNT_W-1:0] = icnt;
            LOC_WCFG: begin
                rd_data[WCNT_W-1:0] = limit_q;
                rd_data[MODE_POS]   = mode_q;
            end
            LOC_WCNT: rd_data[WCNT_W-1:0] = wcnt;
            default:  rd_data = '0;
        endcase
    end

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
        !kick_stb |=> $stable({mode_q, limit_q})); // R10
    AST_EXCL_OUT: assert property (@(posedge clk) disable iff (rst)
        !(wdt_irq && rst_req)); // R8

endmodule

// File: tb/test_tick_watchdog.sv
module test_tick_watchdog;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [1:0] addr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       bit_irq, wdt_irq, rst_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int t0 = 0;
    int n_bit = 0, n_wdt = 0, n_rst = 0;
    bit done = 0;

    tick_watchdog i_tick_watchdog (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .bit_irq(bit_irq), .wdt_irq(wdt_irq), .rst_req(rst_req)
    );

    always #2ns clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (bit_irq) n_bit++;
        if (wdt_irq) n_wdt++;
        if (rst_req) n_rst++;
    end

    function automatic int period(input int sel);
        return 1 << (sel + 3);
    endfunction
    function automatic int exp_icnt(input int m, input int sel);
        return (m / period(sel)) % 256;
    endfunction
    function automatic int fire_dt(input int lim, input int sel);
        return 256 * (lim == 0 ? 64 : lim) * period(sel);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_now(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_now(a, d);
    endtask
    task automatic rd(input logic [1:0] a, output int v);
        addr = a;
        #1ns;
        v = int'(rd_data);
    endtask
    task automatic clear_ivl(input int sel);
        wr(2'd0, 8'h08 | 8'(sel));
        t0 = cyc;
    endtask
    task automatic wait_pulse(input int which, output int dt);
        dt = -1;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if ((which == 0 && bit_irq) || (which == 1 && wdt_irq) || (which == 2 && rst_req)) begin
                dt = cyc - t0;
                return;
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog timeout actual=%0d expected=0", cyc);
        finish_run();
    end

    initial begin
        int v, dt, w0, r0, seed;
        rst = 1'b1; wr_en = 1'b0; addr = 2'd0; wr_data = 8'h00;
        seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); check("R1 ctrl", v, 8'h07);
        rd(2'd2, v); check("R1 wcfg", v, 8'h3F);
        rd(2'd1, v); check("R1 icnt", v, 0);
        rd(2'd3, v); check("R1 wcnt", v, 0);
        check("R1 outputs", {bit_irq, wdt_irq, rst_req}, 0);

        // R2 tap 0, R3 write ignored, R5 clear bit reads 0
        clear_ivl(0);
        repeat (100) @(negedge clk);
        rd(2'd1, v); check("R2 tap0 count", v, exp_icnt(cyc - t0, 0));
        wr(2'd1, 8'hAA);
        rd(2'd1, v); check("R3 write ignored", v, exp_icnt(cyc - t0, 0));
        rd(2'd0, v); check("R5 ctrl readback", v, 0);
        clear_ivl(1);
        repeat (50) @(negedge clk);
        rd(2'd1, v); check("R2 tap1 count", v, exp_icnt(cyc - t0, 1));
        clear_ivl(1);
        rd(2'd1, v); check("R5 clear zeroes count", v, 0);
        rd(2'd0, v); check("R5 sel loaded", v, 1);

        // R4, R6, R7: mode 0, limit 2, tap 0
        wr(2'd2, 8'h02);
        clear_ivl(0);
        r0 = n_rst;
        wait_pulse(0, dt); check("R4 first wrap distance", dt, fire_dt(1, 0));
        rd(2'd1, v); check("R4 count zero at wrap", v, 0);
        rd(2'd3, v); check("R6 wcnt after one wrap", v, 1);
        @(negedge clk); check("R4 one-cycle pulse", bit_irq, 0);
        wait_pulse(1, dt); check("R7 match distance", dt, fire_dt(2, 0));
        rd(2'd3, v); check("R7 count cleared", v, 0);
        check("R7 no reset request", n_rst - r0, 0);

        // R8, R10: mode 1, limit 1
        wr(2'd2, 8'h41);
        rd(2'd2, v); check("R10 readback", v, 8'h41);
        clear_ivl(0);
        w0 = n_wdt;
        wait_pulse(2, dt); check("R8 reset distance", dt, fire_dt(1, 0));
        @(negedge clk); check("R8 one-cycle reset", rst_req, 0);
        check("R8 no watchdog irq", n_wdt - w0, 0);

        // R9 kick postpones the match
        wr(2'd2, 8'h02);
        clear_ivl(0);
        repeat (3072 - (cyc - t0)) @(negedge clk);
        wr(2'd2, 8'h02);
        rd(2'd3, v); check("R9 kick clears", v, 0);
        wait_pulse(1, dt); check("R9 postponed match", dt, 3 * 2048);

        // R9 kick on the exact wrap edge
        wr(2'd2, 8'h03);
        clear_ivl(0);
        repeat (2047) @(negedge clk);
        wr_now(2'd2, 8'h03);
        check("R4 wrap on kick edge", bit_irq, 1);
        rd(2'd3, v); check("R9 kick wins over wrap", v, 0);
        repeat (4096 - (cyc - t0)) @(negedge clk);
        rd(2'd3, v); check("R9 count after next wrap", v, 1);

        // random tap / limit / mode
        for (int k = 0; k < 4; k++) begin
            int sel, lim, mode;
            sel  = int'($urandom_range(1, 0));
            lim  = int'($urandom_range(3, 1));
            mode = int'($urandom_range(1, 0));
            wr(2'd2, 8'((mode << 6) | lim));
            clear_ivl(sel);
            w0 = n_wdt; r0 = n_rst;
            wait_pulse(mode ? 2 : 1, dt);
            check(mode ? "R8 random distance" : "R7 random distance", dt, fire_dt(lim, sel));
            check("R8 other pulse silent", mode ? (n_wdt - w0) : (n_rst - r0), 0);
        end

        finish_run();
    end

endmodule